// File: doc/BRIEF.md
# Three-Share Masked Substitution Layer

This block computes the 5-bit substitution layer of a 320-bit permutation state while the state stays split into three Boolean shares. The true state is the XOR of the three share vectors and is never formed inside the block. Each share goes through the linear input mixing and the linear output mixing on its own. Between the two, a nonlinear core computes three output shares. Each output share is built from only two of the three input shares, so the core has the non-completeness property of a first-order threshold implementation.

To keep the output sharing uniform, bits 3 and 4 of every slice are remasked. The masks are chi-input share bits of the preceding slice. Slice 0 has no preceding slice, so it takes four fresh random bits instead. The whole layer therefore uses four random bits per evaluation. A surrounding round engine supplies the shares and the random bits, and applies the round constant and the diffusion layer to each share outside this block. The three output shares are registered.

Top module: `tsbox_masked_layer`

## Requirements
- R1: Reset is synchronous and active high. At the first clock edge where reset is sampled high, all three output shares become zero, and they stay zero while reset is held.
- R2: Every share vector holds five 64-bit words. Word k occupies bits [k*64 +: 64]. Slice j is the 5-bit lane whose bit k is vector bit k*64+j. Outputs take the values computed from the inputs sampled at the previous clock edge, a latency of one cycle.
- R3: For any sharing and any random bits, the XOR of the three output shares equals the unmasked layer applied to the XOR of the three input shares. The unmasked layer works on each lane x in five steps: x0^=x4, x4^=x3, x2^=x1; then every bit i becomes xi ^ (~x(i+1) & x(i+2)) with indices mod 5; then x1^=x0, x0^=x4, x3^=x2; then x2 is inverted.
- R4: The final inversion of word 2 is applied to output share A only. With all inputs zero, share A output equals all ones in word 2 and zero elsewhere, and shares B and C output zero.
- R5: Output share A in slice j does not depend on input share A in slice j. The same holds for share B and for share C.
- R6: For slices j ≥ 1, the remask bits of slice j are bits 3 and 4 of the chi-input A and B shares of slice j-1, taken after the input mixing. Flipping input share A word 4 at slice j-1 flips output share A at slice j in exactly words 0 and 4, and changes no other bit of output share A.
- R7: Bits 0 to 2 of a slice are never remasked. Flipping input share A word 1 at any slice leaves the whole of output share A unchanged.
- R8: The random bits affect slice 0 only. rand_i[0] is the A-side bit-3 mask and rand_i[1] the B-side bit-3 mask; rand_i[2] is the A-side bit-4 mask and rand_i[3] the B-side bit-4 mask. Output share A takes both sides, output share B takes the A side, and output share C takes the B side. A bit-3 mask flips word 3 of slice 0, and a bit-4 mask flips words 0 and 4 of slice 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| share_a_i | input | 320 | Input share A |
| share_b_i | input | 320 | Input share B |
| share_c_i | input | 320 | Input share C |
| rand_i | input | 4 | Fresh mask bits for slice 0 |
| share_a_o | output | 320 | Registered output share A |
| share_b_o | output | 320 | Registered output share B |
| share_c_o | output | 320 | Registered output share C |

## Verification
The block holds no state apart from its output registers. A wrong linear step or a wrong core term therefore appears in the recombined output exactly one sample after the stimulus. A wiring fault in the remasking is different: it can cancel out of the recombined value and still corrupt the individual shares. To expose such faults, the bench perturbs single bits of a single share, or single random bits. It then compares each output share against an exact predicted delta, which shows a wrong neighbour source, a wrong bit position or a missing cancellation in the cycle after the change.

// File: rtl/tsbox_pkg.sv
`timescale 1ns/1ps
package tsbox_pkg;
  localparam int LANE_W  = 5;
  localparam int RAND_W  = 4;
  localparam int REMASK_W = 2;

  typedef logic [LANE_W-1:0] lane_t;

  // Linear mixing in front of the nonlinear core, applied per share.
  function automatic lane_t lin_pre(input lane_t v);
    lane_t x;
    x = v;
    x[0] = x[0] ^ x[4];
    x[4] = x[4] ^ x[3];
    x[2] = x[2] ^ x[1];
    return x;
  endfunction

  // Linear mixing behind the core; the inversion goes to one share only.
  function automatic lane_t lin_post(input lane_t v, input bit flip);
    lane_t x;
    x = v;
    x[1] = x[1] ^ x[0];
    x[0] = x[0] ^ x[4];
    x[3] = x[3] ^ x[2];
    x[2] = x[2] ^ flip;
    return x;
  endfunction

  // Component function built from two shares (p carries the linear term).
  function automatic lane_t chi_share(input lane_t p, input lane_t q);
    lane_t r;
    for (int i = 0; i < LANE_W; i++) begin
      r[i] = p[i]
           ^ (~p[(i+1)%LANE_W] & p[(i+2)%LANE_W])
           ^ (p[(i+1)%LANE_W] & q[(i+2)%LANE_W])
           ^ (p[(i+2)%LANE_W] & q[(i+1)%LANE_W]);
    end
    return r;
  endfunction
endpackage

// File: rtl/tsbox_affine.sv
`timescale 1ns/1ps
module tsbox_affine
  import tsbox_pkg::*;
#(
  parameter int SLICES = 64,
  parameter bit POST   = 1'b0,
  parameter bit FLIP   = 1'b0,
  localparam int STATE_W = SLICES * LANE_W
) (
  input  logic [STATE_W-1:0] d,
  output logic [STATE_W-1:0] q
);
  logic [SLICES-1:0][LANE_W-1:0] lane_in;
  logic [SLICES-1:0][LANE_W-1:0] lane_out;

  always_comb begin
    for (int j = 0; j < SLICES; j++) begin
      for (int k = 0; k < LANE_W; k++) begin
        lane_in[j][k] = d[k*SLICES + j];
      end
    end
  end

  for (genvar j = 0; j < SLICES; j++) begin : g_slice
    if (POST) begin : g_post
      assign lane_out[j] = lin_post(lane_in[j], FLIP);
    end else begin : g_pre
      assign lane_out[j] = lin_pre(lane_in[j]);
    end
  end

  always_comb begin
    for (int j = 0; j < SLICES; j++) begin
      for (int k = 0; k < LANE_W; k++) begin
        q[k*SLICES + j] = lane_out[j][k];
      end
    end
  end
endmodule

// File: rtl/tsbox_core.sv
`timescale 1ns/1ps
module tsbox_core
  import tsbox_pkg::*;
#(
  parameter int SLICES = 64,
  localparam int STATE_W = SLICES * LANE_W
) (
  input  logic [STATE_W-1:0] a_i,
  input  logic [STATE_W-1:0] b_i,
  input  logic [STATE_W-1:0] c_i,
  input  logic [RAND_W-1:0]  rand_i,
  output logic [STATE_W-1:0] a_o,
  output logic [STATE_W-1:0] b_o,
  output logic [STATE_W-1:0] c_o
);
  localparam int RM_LO = LANE_W - REMASK_W;

  logic [SLICES-1:0][LANE_W-1:0] la, lb, lc;
  logic [SLICES-1:0][LANE_W-1:0] ya, yb, yc;

  always_comb begin
    for (int j = 0; j < SLICES; j++) begin
      for (int k = 0; k < LANE_W; k++) begin
        la[j][k] = a_i[k*SLICES + j];
        lb[j][k] = b_i[k*SLICES + j];
        lc[j][k] = c_i[k*SLICES + j];
      end
    end
  end

  for (genvar j = 0; j < SLICES; j++) begin : g_slice
    logic [REMASK_W-1:0] nbr_a;
    logic [REMASK_W-1:0] nbr_b;
    if (j == 0) begin : g_fresh
      assign nbr_a = {rand_i[2], rand_i[0]};
      assign nbr_b = {rand_i[3], rand_i[1]};
    end else begin : g_reuse
      // Chi-input bits of the previous slice: no chain through core outputs.
      assign nbr_a = la[j-1][LANE_W-1:RM_LO];
      assign nbr_b = lb[j-1][LANE_W-1:RM_LO];
    end
    assign ya[j] = chi_share(lb[j], lc[j]) ^ {nbr_a ^ nbr_b, {RM_LO{1'b0}}};
    assign yb[j] = chi_share(lc[j], la[j]) ^ {nbr_a, {RM_LO{1'b0}}};
    assign yc[j] = chi_share(la[j], lb[j]) ^ {nbr_b, {RM_LO{1'b0}}};
  end

  always_comb begin
    for (int j = 0; j < SLICES; j++) begin
      for (int k = 0; k < LANE_W; k++) begin
        a_o[k*SLICES + j] = ya[j][k];
        b_o[k*SLICES + j] = yb[j][k];
        c_o[k*SLICES + j] = yc[j][k];
      end
    end
  end
endmodule

// File: rtl/tsbox_masked_layer.sv
`timescale 1ns/1ps
module tsbox_masked_layer
  import tsbox_pkg::*;
#(
  parameter int SLICES = 64,
  localparam int STATE_W = SLICES * LANE_W,
  localparam int SHARES  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] share_a_i,
  input  logic [STATE_W-1:0] share_b_i,
  input  logic [STATE_W-1:0] share_c_i,
  input  logic [RAND_W-1:0]  rand_i,
  output logic [STATE_W-1:0] share_a_o,
  output logic [STATE_W-1:0] share_b_o,
  output logic [STATE_W-1:0] share_c_o
);
  logic [STATE_W-1:0] raw   [SHARES];
  logic [STATE_W-1:0] mixed [SHARES];
  logic [STATE_W-1:0] cored [SHARES];
  logic [STATE_W-1:0] final_q [SHARES];

  assign raw[0] = share_a_i;
  assign raw[1] = share_b_i;
  assign raw[2] = share_c_i;

  for (genvar s = 0; s < SHARES; s++) begin : g_share
    tsbox_affine #(.SLICES(SLICES), .POST(1'b0), .FLIP(1'b0)) u_pre (
      .d(raw[s]),
      .q(mixed[s])
    );
    tsbox_affine #(.SLICES(SLICES), .POST(1'b1), .FLIP(s == 0)) u_post (
      .d(cored[s]),
      .q(final_q[s])
    );
  end

  tsbox_core #(.SLICES(SLICES)) u_core (
    .a_i(mixed[0]),
    .b_i(mixed[1]),
    .c_i(mixed[2]),
    .rand_i(rand_i),
    .a_o(cored[0]),
    .b_o(cored[1]),
    .c_o(cored[2])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      share_a_o <= '0;
      share_b_o <= '0;
      share_c_o <= '0;
    end else begin
      share_a_o <= final_q[0];
      share_b_o <= final_q[1];
      share_c_o <= final_q[2];
    end
  end

  // ---------------- assertions ----------------
  logic live;
  always_ff @(posedge clk) live <= !rst;

  function automatic logic [STATE_W-1:0] slice_mask(input int s);
    logic [STATE_W-1:0] m;
    m = '0;
    for (int k = 0; k < LANE_W; k++) m[k*SLICES + s] = 1'b1;
    return m;
  endfunction

  localparam logic [STATE_W-1:0] FIRST_M = slice_mask(0);
  localparam logic [STATE_W-1:0] LAST_M  = slice_mask(SLICES-1);

  // Unmasked reference on the recombined state.
  function automatic logic [STATE_W-1:0] unmasked_layer(input logic [STATE_W-1:0] x);
    logic [STATE_W-1:0] y;
    lane_t l;
    for (int j = 0; j < SLICES; j++) begin
      for (int k = 0; k < LANE_W; k++) l[k] = x[k*SLICES + j];
      l = lin_post(chi_share(lin_pre(l), '0), 1'b1);
      for (int k = 0; k < LANE_W; k++) y[k*SLICES + j] = l[k];
    end
    return y;
  endfunction

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (share_a_o == '0 && share_b_o == '0 && share_c_o == '0));

  assert_recombine_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((share_a_o ^ share_b_o ^ share_c_o) ==
              unmasked_layer($past(share_a_i ^ share_b_i ^ share_c_i))));

  // R5: share A at the last slice reaches no bit of output share A.
  assert_a_blind_R5: assert property (@(posedge clk) disable iff (rst)
    (live && $stable(share_b_i) && $stable(share_c_i) && $stable(rand_i) &&
     (((share_a_i ^ $past(share_a_i)) & ~LAST_M) == '0))
    |=> $stable(share_a_o));

  assert_rand_slice0_R8: assert property (@(posedge clk) disable iff (rst)
    (live && $stable(share_a_i) && $stable(share_b_i) && $stable(share_c_i))
    |=> ($stable(share_a_o & ~FIRST_M) && $stable(share_b_o & ~FIRST_M) &&
         $stable(share_c_o & ~FIRST_M)));
endmodule

// File: tb/tsbox_masked_layer_bench.sv
`timescale 1ns/1ps
module tsbox_masked_layer_bench;
  localparam int SL = 64;
  localparam int SW = 320;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic [SW-1:0] a_i, b_i, c_i;
  logic [3:0]    r_i;
  logic [SW-1:0] a_o, b_o, c_o;

  int n_chk = 0;
  int n_bad = 0;

  tsbox_masked_layer u_tsbox_masked_layer (
    .clk(clk), .rst(rst),
    .share_a_i(a_i), .share_b_i(b_i), .share_c_i(c_i), .rand_i(r_i),
    .share_a_o(a_o), .share_b_o(b_o), .share_c_o(c_o)
  );

  task automatic check_eq(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] rnd_state();
    logic [SW-1:0] v;
    for (int w = 0; w < SW/32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  // Bits of slice j for the words selected in w (bit k = word k).
  function automatic logic [SW-1:0] wbits(input int j, input logic [4:0] w);
    logic [SW-1:0] m;
    m = '0;
    for (int k = 0; k < 5; k++) m[k*SL + j] = w[k];
    return m;
  endfunction

  function automatic logic [4:0] sbox5(input logic [4:0] v);
    logic [4:0] x, t;
    x = v;
    x[0] ^= x[4]; x[4] ^= x[3]; x[2] ^= x[1];
    for (int i = 0; i < 5; i++) t[i] = x[i] ^ (~x[(i+1)%5] & x[(i+2)%5]);
    x = t;
    x[1] ^= x[0]; x[0] ^= x[4]; x[3] ^= x[2]; x[2] = ~x[2];
    return x;
  endfunction

  function automatic logic [SW-1:0] ref_state(input logic [SW-1:0] x);
    logic [SW-1:0] y;
    logic [4:0] l;
    for (int j = 0; j < SL; j++) begin
      for (int k = 0; k < 5; k++) l[k] = x[k*SL + j];
      l = sbox5(l);
      for (int k = 0; k < 5; k++) y[k*SL + j] = l[k];
    end
    return y;
  endfunction

  function automatic logic [SW-1:0] pick(input int s);
    return (s == 0) ? a_o : (s == 1) ? b_o : c_o;
  endfunction

  task automatic apply(input logic [SW-1:0] a, input logic [SW-1:0] b,
                       input logic [SW-1:0] c, input logic [3:0] r);
    @(negedge clk);
    a_i = a; b_i = b; c_i = c; r_i = r;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    a_i = rnd_state(); b_i = rnd_state(); c_i = rnd_state(); r_i = 4'hF;
    repeat (2) @(negedge clk);
    check_eq("R1 share A in reset", a_o, '0);
    check_eq("R1 share B in reset", b_o, '0);
    check_eq("R1 share C in reset", c_o, '0);
    rst = 1'b0;
  endtask

  task automatic t_const_share();
    logic [SW-1:0] e;
    e = '0;
    for (int j = 0; j < SL; j++) e |= wbits(j, 5'b00100);
    apply('0, '0, '0, 4'h0);
    check_eq("R4 share A inversion", a_o, e);
    check_eq("R4 share B zero", b_o, '0);
    check_eq("R4 share C zero", c_o, '0);
  endtask

  task automatic t_recombine();
    logic [SW-1:0] a, b, c;
    for (int n = 0; n < 40; n++) begin
      a = rnd_state(); b = rnd_state(); c = rnd_state();
      apply(a, b, c, 4'($urandom));
      check_eq("R2 R3 recombined output", a_o ^ b_o ^ c_o, ref_state(a ^ b ^ c));
    end
    // single-lane pattern to pin the slice layout
    apply(wbits(9, 5'b00001), '0, '0, 4'h0);
    check_eq("R2 single lane layout", a_o ^ b_o ^ c_o, ref_state(wbits(9, 5'b00001)));
  endtask

  task automatic t_noncomplete();
    logic [SW-1:0] a, b, c, base, m;
    int js [3] = '{0, 17, 63};
    for (int s = 0; s < 3; s++) begin
      for (int q = 0; q < 3; q++) begin
        a = rnd_state(); b = rnd_state(); c = rnd_state();
        m = wbits(js[q], 5'h1F);
        apply(a, b, c, 4'h5);
        base = pick(s);
        if (s == 0) a ^= m; else if (s == 1) b ^= m; else c ^= m;
        apply(a, b, c, 4'h5);
        check_eq("R5 own share slice independence", pick(s) & m, base & m);
      end
    end
  endtask

  task automatic t_neighbour();
    logic [SW-1:0] a, b, c, base;
    int js [3] = '{1, 30, 63};
    for (int q = 0; q < 3; q++) begin
      a = rnd_state(); b = rnd_state(); c = rnd_state();
      apply(a, b, c, 4'h0);
      base = a_o;
      apply(a ^ wbits(js[q]-1, 5'b10000), b, c, 4'h0);
      check_eq("R6 neighbour remask delta", a_o, base ^ wbits(js[q], 5'b10001));
    end
  endtask

  task automatic t_low_bits();
    logic [SW-1:0] a, b, c, base;
    int js [3] = '{0, 40, 62};
    for (int q = 0; q < 3; q++) begin
      a = rnd_state(); b = rnd_state(); c = rnd_state();
      apply(a, b, c, 4'h0);
      base = a_o;
      apply(a ^ wbits(js[q], 5'b00010), b, c, 4'h0);
      check_eq("R7 low bits not remasked", a_o, base);
    end
  endtask

  task automatic t_rand();
    logic [SW-1:0] a, b, c, ba, bb, bc, d;
    a = rnd_state(); b = rnd_state(); c = rnd_state();
    apply(a, b, c, 4'h0);
    ba = a_o; bb = b_o; bc = c_o;
    for (int q = 0; q < 4; q++) begin
      d = (q < 2) ? wbits(0, 5'b01000) : wbits(0, 5'b10001);
      apply(a, b, c, 4'(1 << q));
      check_eq("R8 random bit into share A", a_o, ba ^ d);
      check_eq("R8 random bit into share B", b_o, (q % 2 == 0) ? (bb ^ d) : bb);
      check_eq("R8 random bit into share C", c_o, (q % 2 == 1) ? (bc ^ d) : bc);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    a_i = '0; b_i = '0; c_i = '0; r_i = '0;
    t_reset();
    t_const_share();
    t_recombine();
    t_noncomplete();
    t_neighbour();
    t_low_bits();
    t_rand();
    summary();
    $finish;
  end
endmodule